// File: doc/BRIEF.md
# Function-Bounds Branch Guard

This block watches committed control transfers and flags those that leave the function currently executing. It keeps a hardware stack of frames. Each frame holds three values: the entry address of the active function, the first address past its end, and the address that a return from it must reach. Calls push a frame. Returns pop a frame. Indirect jumps are compared against the top frame.

A call is accepted only when the word stored at its target is a valid entry annotation. The upper bits of that word hold a fixed marker, and the lower bits give the function size. The annotation word is fetched elsewhere and arrives with the branch. Only a few frames are held on chip. When a call arrives and that cache is full, the oldest frame is written out to an external backing store through a request/acknowledge port. When the cache becomes empty while frames are still held outside, the most recent spilled frame is read back. Checking stalls until the read is acknowledged.

The commit logic presents one branch at a time with `br_valid`. It holds the branch until `br_ready` is high. One cycle after the branch is accepted, `viol` reports the verdict.

Top module: `branch_bounds_guard`

## Requirements
- R1: After reset `viol` is 0, `br_ready` is 1, `bs_req` is 0 and the frame stack is empty.
- R2: Calls use kind 1 (direct) or kind 3 (indirect). A call whose annotation has upper 16 bits equal to 16'hB0DA is clean and pushes the frame {target, target + annotation[15:0], next_pc}. A call whose annotation has any other marker is a violation and pushes nothing.
- R3: A direct jump (kind 0) is never a violation and leaves the stack unchanged.
- R4: An indirect jump (kind 2) whose target satisfies base <= target < base+size for the top frame is clean. If the target falls outside that range, including target = base+size, and the annotation is invalid, the jump is a violation.
- R5: An indirect jump to a target with a valid annotation is clean and pushes nothing.
- R6: A return (kind 4) whose target equals the top frame's return address is clean. A return to any other target is a violation. In both cases the top frame is popped.
- R7: A return when no frame exists, neither cached nor spilled, is a violation.
- R8: `viol` is registered. It is high exactly in the cycle after the violating branch is accepted and lasts one cycle.
- R9: A call with all 4 cache slots occupied makes `br_ready` drop and raises a write request. The request carries `bs_addr` equal to the number of frames already spilled and `bs_wdata` equal to the oldest frame, packed base, bound, return with base in the MSBs. The new frame is pushed when `bs_ack` arrives.
- R10: When the cache is empty and frames are spilled, `br_ready` stays low while a read request at address (spilled count - 1) is outstanding. The frame from `bs_rdata` becomes the top frame on `bs_ack`.
- R11: A valid call when the cache and the 8-entry backing store are both full is a violation and pushes nothing.
- R12: With no frame present, an indirect jump is clean only if its target carries a valid annotation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| br_valid | input | 1 | A committed branch is presented |
| br_ready | output | 1 | Block can accept a branch this cycle |
| br_kind | input | 3 | 0 direct jump, 1 direct call, 2 indirect jump, 3 indirect call, 4 return |
| br_target | input | AW | Branch target address |
| br_next_pc | input | AW | Address after the branch (return address for calls) |
| br_annot | input | ANW | Word read at the target: marker in MSBs, size in LSBs |
| viol | output | 1 | Violation verdict for the branch accepted last cycle |
| bs_req | output | 1 | Backing store access pending |
| bs_write | output | 1 | 1 spill (write), 0 refill (read) |
| bs_addr | output | log2(BACK_DEPTH) | Backing store slot |
| bs_wdata | output | 3*AW | Frame being spilled |
| bs_rdata | input | 3*AW | Frame returned on a refill |
| bs_ack | input | 1 | Completes the pending access |

## Verification
The assertions assume the following about the environment:

- `bs_ack` is raised only while `bs_req` is high, for a single cycle.
- `bs_rdata` is valid in that same cycle.
- A branch stays stable while `br_valid` waits on `br_ready`.

The bench's backing store model always answers after a fixed delay and stores what was written. Branches are driven only once `br_ready` is high. A reference stack, counting cached and spilled frames together as one store of 12, predicts every verdict. That reference is driven through sweeps of jump offsets around the function bounds and through a full nest-and-unwind beyond capacity.

// File: rtl/brreg_pkg.sv
package brreg_pkg;
  typedef enum logic [2:0] {
    BK_DJMP  = 3'd0,
    BK_DCALL = 3'd1,
    BK_IJMP  = 3'd2,
    BK_ICALL = 3'd3,
    BK_RET   = 3'd4
  } br_kind_e;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_SPILL = 2'd1,
    ST_FILL  = 2'd2
  } guard_state_e;
endpackage

// File: rtl/frame_cache.sv
module frame_cache #(
  parameter int AW    = 32,
  parameter int DEPTH = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            push,
  input  logic            pop,
  input  logic            drop_old,
  input  logic [3*AW-1:0] push_data,
  output logic [3*AW-1:0] top_data,
  output logic [3*AW-1:0] old_data,
  output logic [$clog2(DEPTH+1)-1:0] cnt
);
  localparam int EW = 3*AW;
  localparam int IW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [EW-1:0] slots [DEPTH];
  logic [IW-1:0] head;
  logic [IW-1:0] wr_idx;
  logic [IW-1:0] top_idx;

  // ring buffer: DEPTH is a power of two so index arithmetic wraps
  assign wr_idx   = head + cnt[IW-1:0];
  assign top_idx  = head + cnt[IW-1:0] - IW'(1);
  assign top_data = slots[top_idx];
  assign old_data = slots[head];

  always_ff @(posedge clk) begin
    if (push) slots[wr_idx] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head <= '0;
      cnt  <= '0;
    end else begin
      head <= head + IW'(drop_old);
      cnt  <= cnt + CW'(push) - CW'(pop) - CW'(drop_old);
    end
  end

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
    (push && !drop_old) |-> (cnt < CW'(DEPTH)));
  p_no_underflow_r6: assert property (@(posedge clk) disable iff (rst)
    (pop || drop_old) |-> (cnt != '0));
endmodule

// File: rtl/branch_judge.sv
module branch_judge
  import brreg_pkg::*;
#(
  parameter int AW  = 32,
  parameter int ANW = 32,
  parameter int MKW = 16,
  parameter logic [MKW-1:0] MARK = 16'hB0DA
) (
  input  logic [2:0]      kind,
  input  logic [AW-1:0]   target,
  input  logic [AW-1:0]   next_pc,
  input  logic [ANW-1:0]  annot,
  input  logic [3*AW-1:0] top_entry,
  input  logic            top_ok,
  output logic            bad,
  output logic            want_push,
  output logic            want_pop,
  output logic [3*AW-1:0] new_entry
);
  localparam int EW  = 3*AW;
  localparam int SZW = ANW - MKW;

  logic [AW-1:0] top_base, top_bound, top_ret, fsize;
  logic          entry_ok, in_range;

  assign top_base  = top_entry[EW-1 -: AW];
  assign top_bound = top_entry[2*AW-1 -: AW];
  assign top_ret   = top_entry[AW-1:0];
  assign entry_ok  = (annot[ANW-1 -: MKW] == MARK);
  assign fsize     = AW'(annot[SZW-1:0]);
  assign in_range  = top_ok && (target >= top_base) && (target < top_bound);
  assign new_entry = {target, target + fsize, next_pc};

  always_comb begin
    bad       = 1'b0;
    want_push = 1'b0;
    want_pop  = 1'b0;
    case (kind)
      BK_DCALL, BK_ICALL: begin
        bad       = !entry_ok;
        want_push = entry_ok;
      end
      BK_IJMP: bad = !(in_range || entry_ok);
      BK_RET: begin
        if (!top_ok) bad = 1'b1;
        else begin
          bad      = (target != top_ret);
          want_pop = 1'b1;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/branch_bounds_guard.sv
module branch_bounds_guard
  import brreg_pkg::*;
#(
  parameter int AW         = 32,
  parameter int DEPTH      = 4,
  parameter int BACK_DEPTH = 8,
  parameter int ANW        = 32,
  parameter int MKW        = 16,
  parameter logic [MKW-1:0] MARK = 16'hB0DA
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          br_valid,
  output logic                          br_ready,
  input  logic [2:0]                    br_kind,
  input  logic [AW-1:0]                 br_target,
  input  logic [AW-1:0]                 br_next_pc,
  input  logic [ANW-1:0]                br_annot,
  output logic                          viol,
  output logic                          bs_req,
  output logic                          bs_write,
  output logic [$clog2(BACK_DEPTH)-1:0] bs_addr,
  output logic [3*AW-1:0]               bs_wdata,
  input  logic [3*AW-1:0]               bs_rdata,
  input  logic                          bs_ack
);
  localparam int EW = 3*AW;
  localparam int CW = $clog2(DEPTH+1);
  localparam int BW = $clog2(BACK_DEPTH);
  localparam int SW = $clog2(BACK_DEPTH+1);

  guard_state_e  state;
  logic [SW-1:0] spilled;
  logic [EW-1:0] pend;
  logic          viol_q;

  logic [CW-1:0] c_cnt;
  logic [EW-1:0] c_top, c_old, c_push_data;
  logic          c_push, c_pop, c_drop;
  logic          j_bad, j_push, j_pop;
  logic [EW-1:0] j_entry;
  logic          accept, full, back_full, need_fill, overflow, need_spill;

  frame_cache #(.AW(AW), .DEPTH(DEPTH)) u_cache (
    .clk(clk), .rst(rst), .push(c_push), .pop(c_pop), .drop_old(c_drop),
    .push_data(c_push_data), .top_data(c_top), .old_data(c_old), .cnt(c_cnt)
  );

  branch_judge #(.AW(AW), .ANW(ANW), .MKW(MKW), .MARK(MARK)) u_judge (
    .kind(br_kind), .target(br_target), .next_pc(br_next_pc), .annot(br_annot),
    .top_entry(c_top), .top_ok(c_cnt != '0),
    .bad(j_bad), .want_push(j_push), .want_pop(j_pop), .new_entry(j_entry)
  );

  assign full       = (c_cnt == CW'(DEPTH));
  assign back_full  = (spilled == SW'(BACK_DEPTH));
  assign need_fill  = (c_cnt == '0) && (spilled != '0);
  assign br_ready   = (state == ST_RUN) && !need_fill;
  assign accept     = br_valid && br_ready;
  assign overflow   = accept && j_push && full && back_full;
  assign need_spill = accept && j_push && full && !back_full;

  // cache control: a spill drops the oldest frame and pushes the held one together
  assign c_push = (accept && j_push && !full)
               || ((state == ST_SPILL) && bs_ack)
               || ((state == ST_FILL) && bs_ack);
  assign c_drop = (state == ST_SPILL) && bs_ack;
  assign c_pop  = accept && j_pop;
  always_comb begin
    case (state)
      ST_SPILL: c_push_data = pend;
      ST_FILL:  c_push_data = bs_rdata;
      default:  c_push_data = j_entry;
    endcase
  end

  assign bs_req   = (state != ST_RUN);
  assign bs_write = (state == ST_SPILL);
  assign bs_addr  = (state == ST_SPILL) ? spilled[BW-1:0] : spilled[BW-1:0] - BW'(1);
  assign bs_wdata = c_old;
  assign viol     = viol_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_RUN;
      spilled <= '0;
      pend    <= '0;
      viol_q  <= 1'b0;
    end else begin
      viol_q <= accept && (j_bad || overflow);
      case (state)
        ST_RUN: begin
          if (need_fill) state <= ST_FILL;
          else if (need_spill) begin
            state <= ST_SPILL;
            pend  <= j_entry;
          end
        end
        ST_SPILL: if (bs_ack) begin
          state   <= ST_RUN;
          spilled <= spilled + SW'(1);
        end
        ST_FILL: if (bs_ack) begin
          state   <= ST_RUN;
          spilled <= spilled - SW'(1);
        end
        default: state <= ST_RUN;
      endcase
    end
  end

  p_stall_on_mem_r10: assert property (@(posedge clk) disable iff (rst)
    bs_req |-> !br_ready);
  p_req_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (bs_req && !bs_ack) |=> (bs_req && $stable(bs_addr) && $stable(bs_write)));
  p_spill_when_full_r9: assert property (@(posedge clk) disable iff (rst)
    (bs_req && bs_write) |-> (c_cnt == CW'(DEPTH)));
  p_fill_when_empty_r10: assert property (@(posedge clk) disable iff (rst)
    (bs_req && !bs_write) |-> (c_cnt == '0));
  p_viol_after_accept_r8: assert property (@(posedge clk) disable iff (rst)
    viol |-> $past(accept));
  p_djmp_clean_r3: assert property (@(posedge clk) disable iff (rst)
    (accept && br_kind == 3'd0) |=> !viol);
  p_ret_empty_r7: assert property (@(posedge clk) disable iff (rst)
    (accept && br_kind == 3'd4 && c_cnt == '0 && spilled == '0) |=> viol);
endmodule

// File: tb/tb_branch_bounds_guard.sv
module tb_branch_bounds_guard;
  localparam int AW = 32;
  localparam logic [15:0] MARK = 16'hB0DA;
  localparam int CAP = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic br_valid = 1'b0;
  logic br_ready;
  logic [2:0] br_kind = '0;
  logic [31:0] br_target = '0, br_next_pc = '0, br_annot = '0;
  logic viol, bs_req, bs_write, bs_ack;
  logic [2:0] bs_addr;
  logic [95:0] bs_wdata, bs_rdata;

  int total = 0, bad = 0;
  bit finished = 0;

  logic [95:0] bmem [8];
  logic [2:0]  log_waddr, log_raddr;
  logic [95:0] log_wdata;

  logic [31:0] g_base [CAP], g_bound [CAP], g_ret [CAP];
  int gsp = 0;

  always #2.5 clk = ~clk;

  branch_bounds_guard dut (
    .clk(clk), .rst(rst), .br_valid(br_valid), .br_ready(br_ready),
    .br_kind(br_kind), .br_target(br_target), .br_next_pc(br_next_pc),
    .br_annot(br_annot), .viol(viol), .bs_req(bs_req), .bs_write(bs_write),
    .bs_addr(bs_addr), .bs_wdata(bs_wdata), .bs_rdata(bs_rdata), .bs_ack(bs_ack)
  );

  task automatic check(input string tag, input logic [95:0] act, input logic [95:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // backing store model: answers two cycles after a request
  initial begin
    bs_ack = 1'b0;
    bs_rdata = '0;
    forever begin
      @(negedge clk);
      bs_ack = 1'b0;
      if (bs_req) begin
        @(negedge clk);
        if (bs_write) begin
          bmem[bs_addr] = bs_wdata;
          log_waddr = bs_addr;
          log_wdata = bs_wdata;
        end else begin
          bs_rdata  = bmem[bs_addr];
          log_raddr = bs_addr;
        end
        bs_ack = 1'b1;
      end
    end
  end

  // one branch; expected verdict from a reference stack of capacity CAP
  task automatic br(input logic [2:0] k, input logic [31:0] tg, input logic [31:0] np,
                    input logic [31:0] an, input string tag);
    logic exp_v;
    logic ok_an;
    ok_an = (an[31:16] == MARK);
    exp_v = 1'b0;
    case (k)
      3'd1, 3'd3: begin
        if (!ok_an || gsp == CAP) exp_v = 1'b1;
        else begin
          g_base[gsp] = tg; g_bound[gsp] = tg + {16'h0, an[15:0]}; g_ret[gsp] = np;
          gsp++;
        end
      end
      3'd2: exp_v = !(ok_an || (gsp > 0 && tg >= g_base[gsp-1] && tg < g_bound[gsp-1]));
      3'd4: begin
        if (gsp == 0) exp_v = 1'b1;
        else begin
          exp_v = (tg != g_ret[gsp-1]);
          gsp--;
        end
      end
      default: exp_v = 1'b0;
    endcase
    while (!br_ready) @(negedge clk);
    br_valid = 1'b1; br_kind = k; br_target = tg; br_next_pc = np; br_annot = an;
    @(negedge clk);
    br_valid = 1'b0;
    check(tag, {95'd0, viol}, {95'd0, exp_v});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 viol", {95'd0, viol}, 96'd0);
    check("R1 ready", {95'd0, br_ready}, 96'd1);
    check("R1 req", {95'd0, bs_req}, 96'd0);

    for (int i = 0; i < 6; i++) br(3'd0, 32'h40 + i * 32'h333, 32'h10, 32'h0, "R3");
    br(3'd4, 32'h500, 32'h0, 32'h0, "R7");
    @(negedge clk);
    check("R8 one-cycle", {95'd0, viol}, 96'd0);
    br(3'd2, 32'h1234, 32'h0, 32'h0, "R12");
    br(3'd2, 32'h1234, 32'h0, {MARK, 16'h10}, "R12");

    br(3'd3, 32'h1000, 32'h500, {MARK, 16'h0098}, "R2");
    for (int off = -4; off <= 32'h9C; off++)
      br(3'd2, 32'h1000 + off, 32'h0, 32'h0, "R4");
    br(3'd2, 32'h7000, 32'h0, {MARK, 16'h20}, "R5");
    br(3'd0, 32'h9000, 32'h0, 32'h0, "R3");
    br(3'd2, 32'h1097, 32'h0, 32'h0, "R4 top unchanged");
    br(3'd1, 32'h3000, 32'h600, {16'hB0DB, 16'h40}, "R2");
    br(3'd4, 32'h500, 32'h0, 32'h0, "R6");
    br(3'd4, 32'h500, 32'h0, 32'h0, "R7");

    br(3'd1, 32'h4000, 32'h700, {MARK, 16'h10}, "R2");
    br(3'd4, 32'h704, 32'h0, 32'h0, "R6");
    br(3'd4, 32'h700, 32'h0, 32'h0, "R7");

    for (int i = 0; i < 13; i++) begin
      br(3'd1, 32'h2000 + i * 32'h100, 32'h8000 + i * 4, {MARK, 16'h40}, "R9 R11");
      if (i >= 4 && i < 12) begin
        check("R9 ready low", {95'd0, br_ready}, 96'd0);
        while (!br_ready) @(negedge clk);
        check("R9 addr", {93'd0, log_waddr}, 96'(i - 4));
        check("R9 data", log_wdata, {32'h2000 + (i - 4) * 32'h100,
                                     32'h2040 + (i - 4) * 32'h100, 32'h8000 + (i - 4) * 4});
      end
    end
    br(3'd2, 32'h2B3F, 32'h0, 32'h0, "R4 nested");
    br(3'd2, 32'h2B40, 32'h0, 32'h0, "R4 nested");
    for (int i = 11; i >= 0; i--) begin
      br(3'd4, 32'h8000 + i * 4, 32'h0, 32'h0, "R6 R10");
      if (i <= 8 && i > 0) begin
        @(negedge clk);
        check("R10 ready low", {95'd0, br_ready}, 96'd0);
        while (!br_ready) @(negedge clk);
        check("R10 addr", {93'd0, log_raddr}, 96'(i - 1));
        br(3'd2, 32'h2000 + (i - 1) * 32'h100 + 32'h3F, 32'h0, 32'h0, "R10 bounds");
      end
    end
    br(3'd4, 32'h8000, 32'h0, 32'h0, "R7");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule